// File: doc/BRIEF.md
# Logic Cell Register Bank with Nibble Controls

This block is the storage stage that sits behind the lookup tables of a programmable logic cell. It holds eight main flip-flops, arranged as two groups of four (nibbles), and one extra spare flip-flop. A single clock drives all nine.

Static configuration inputs set how each nibble responds to the shared clock enable and the shared local set/reset. Each nibble chooses for itself whether to obey the enable and whether to obey the set/reset. It also chooses the value that set/reset forces, and whether its four bits load from the lookup-table outputs or from the cell's direct data inputs. The spare flip-flop always loads from its own direct input and has its own enable, set/reset and force-value settings.

Local set/reset is synchronous and wins over clock enable. The power-on reset input clears every flip-flop to 0. A nibble that does not obey the enable loads on every clock edge.

Top module: `lcr_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, all bits of `q` and `spare_q` become 0 at that edge, whatever the other inputs are.
- R2: Each nibble n (bits 4n+3..4n of `q`) loads from `lut_out` when `use_direct[n]` is 0 and from `dir_in` when `use_direct[n]` is 1, independently of the other nibble.
- R3: When `honour_ce[n]` is 1, `ce` is 0 and set/reset is not in effect for nibble n, that nibble keeps its value across the clock edge.
- R4: When `honour_ce[n]` is 0, nibble n loads its selected data at every edge, whatever `ce` is.
- R5: When `honour_lsr[n]` is 1 and `lsr` is 1, nibble n takes all four bits equal to `lsr_level[n]` at the next edge (0 forces 0000, 1 forces 1111).
- R6: Set/reset has priority over clock enable: a nibble that obeys both is forced by `lsr` even when `ce` is 0.
- R7: When `honour_lsr[n]` is 0, `lsr` has no effect on nibble n, which loads or holds as its enable setting dictates.
- R8: `spare_q` loads `spare_d`, obeying `ce` only when `spare_honour_ce` is 1 and `lsr` only when `spare_honour_lsr` is 1, with force value `spare_lsr_level`. Its settings are independent of the nibbles.
- R9: Outputs change only at a rising clock edge: a new input shows at `q` one edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all nine flip-flops |
| rst | input | 1 | Synchronous active-high power-on reset |
| ce | input | 1 | Shared clock enable |
| lsr | input | 1 | Shared synchronous local set/reset |
| lut_out | input | 8 | Lookup-table outputs, one per main flip-flop |
| dir_in | input | 8 | Direct data inputs, one per main flip-flop |
| spare_d | input | 1 | Data input of the spare flip-flop |
| honour_ce | input | 2 | Per nibble: 1 = obey `ce` |
| honour_lsr | input | 2 | Per nibble: 1 = obey `lsr` |
| lsr_level | input | 2 | Per nibble: value forced by set/reset |
| use_direct | input | 2 | Per nibble: 1 = load `dir_in`, 0 = load `lut_out` |
| spare_honour_ce | input | 1 | Spare flip-flop obeys `ce` |
| spare_honour_lsr | input | 1 | Spare flip-flop obeys `lsr` |
| spare_lsr_level | input | 1 | Value forced into the spare flip-flop |
| q | output | 8 | Main flip-flop outputs |
| spare_q | output | 1 | Spare flip-flop output |

## Verification
Every storage bit drives a port directly, so a wrong internal state appears at `q` or `spare_q` one edge after the stimulus that caused it. The tests cross the two nibbles with different settings in the same cycle. As a result, a control that is wired to the wrong nibble, or a priority between set/reset and enable that is reversed, shows up as a mismatch in one nibble while the other nibble is still correct. The same happens for a spare flip-flop that follows nibble settings instead of its own.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    typedef struct packed {
        logic honour_ce;
        logic honour_lsr;
        logic lsr_level;
        logic use_direct;
    } nib_cfg_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_FORCE = 2'd2
    } reg_action_t;

    // Set/reset outranks enable; an element that ignores enable always loads.
    function automatic reg_action_t pick_action(
        input logic honour_ce,
        input logic honour_lsr,
        input logic ce,
        input logic lsr
    );
        if (honour_lsr && lsr)
            return ACT_FORCE;
        else if (!honour_ce || ce)
            return ACT_LOAD;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/lcr_nibble.sv
module lcr_nibble
    import lcr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  nib_cfg_t     cfg,
    input  logic         ce,
    input  logic         lsr,
    input  logic [W-1:0] lut_d,
    input  logic [W-1:0] dir_d,
    output logic [W-1:0] q
);

    reg_action_t  act;
    logic [W-1:0] d_src;

    always_comb d_src = cfg.use_direct ? dir_d : lut_d;
    always_comb act   = pick_action(cfg.honour_ce, cfg.honour_lsr, ce, lsr);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (act)
                ACT_FORCE: q <= {W{cfg.lsr_level}};
                ACT_LOAD:  q <= d_src;
                default:   q <= q;
            endcase
        end
    end

    // R3: enable obeyed and low, no set/reset -> hold
    a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (cfg.honour_ce && !ce && !(cfg.honour_lsr && lsr)) |=> $stable(q));

    // R5 and R6: set/reset forces the configured level regardless of ce
    a_r5_force_level: assert property (@(posedge clk) disable iff (rst)
        (cfg.honour_lsr && lsr) |=> (q == {W{$past(cfg.lsr_level)}}));

    // R2 and R4: free-running nibble captures the chosen source
    a_r4_free_load: assert property (@(posedge clk) disable iff (rst)
        (!cfg.honour_ce && !(cfg.honour_lsr && lsr)) |=>
        (q == ($past(cfg.use_direct) ? $past(dir_d) : $past(lut_d))));

endmodule

// File: rtl/lcr_spare.sv
module lcr_spare
    import lcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic honour_ce,
    input  logic honour_lsr,
    input  logic lsr_level,
    input  logic ce,
    input  logic lsr,
    input  logic d,
    output logic q
);

    reg_action_t act;

    always_comb act = pick_action(honour_ce, honour_lsr, ce, lsr);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (act)
                ACT_FORCE: q <= lsr_level;
                ACT_LOAD:  q <= d;
                default:   q <= q;
            endcase
        end
    end

    // R8: spare element follows its own controls
    a_r8_spare_force: assert property (@(posedge clk) disable iff (rst)
        (honour_lsr && lsr) |=> (q == $past(lsr_level)));

    a_r8_spare_hold: assert property (@(posedge clk) disable iff (rst)
        (honour_ce && !ce && !(honour_lsr && lsr)) |=> $stable(q));

    a_r8_spare_load: assert property (@(posedge clk) disable iff (rst)
        (!honour_ce && !(honour_lsr && lsr)) |=> (q == $past(d)));

endmodule

// File: rtl/lcr_bank.sv
module lcr_bank
    import lcr_pkg::*;
#(
    parameter int NIBBLES = 2,
    parameter int NIB_W   = 4,
    localparam int MAIN_W = NIBBLES * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              lsr,
    input  logic [MAIN_W-1:0] lut_out,
    input  logic [MAIN_W-1:0] dir_in,
    input  logic              spare_d,
    input  logic [NIBBLES-1:0] honour_ce,
    input  logic [NIBBLES-1:0] honour_lsr,
    input  logic [NIBBLES-1:0] lsr_level,
    input  logic [NIBBLES-1:0] use_direct,
    input  logic              spare_honour_ce,
    input  logic              spare_honour_lsr,
    input  logic              spare_lsr_level,
    output logic [MAIN_W-1:0] q,
    output logic              spare_q
);

    nib_cfg_t nib_cfg [NIBBLES];

    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        always_comb begin
            nib_cfg[n].honour_ce  = honour_ce[n];
            nib_cfg[n].honour_lsr = honour_lsr[n];
            nib_cfg[n].lsr_level  = lsr_level[n];
            nib_cfg[n].use_direct = use_direct[n];
        end

        lcr_nibble #(.W(NIB_W)) u_nib (
            .clk   (clk),
            .rst   (rst),
            .cfg   (nib_cfg[n]),
            .ce    (ce),
            .lsr   (lsr),
            .lut_d (lut_out[n*NIB_W +: NIB_W]),
            .dir_d (dir_in[n*NIB_W +: NIB_W]),
            .q     (q[n*NIB_W +: NIB_W])
        );
    end

    lcr_spare u_spare (
        .clk        (clk),
        .rst        (rst),
        .honour_ce  (spare_honour_ce),
        .honour_lsr (spare_honour_lsr),
        .lsr_level  (spare_lsr_level),
        .ce         (ce),
        .lsr        (lsr),
        .d          (spare_d),
        .q          (spare_q)
    );

    // R1: reset clears every element at the next edge
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0 && spare_q == 1'b0));

endmodule

// File: tb/test_lcr_bank.sv
module test_lcr_bank;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce, lsr;
    logic [7:0] lut_out, dir_in;
    logic       spare_d;
    logic [1:0] honour_ce, honour_lsr, lsr_level, use_direct;
    logic       spare_honour_ce, spare_honour_lsr, spare_lsr_level;
    logic [7:0] q;
    logic       spare_q;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lcr_bank i_lcr_bank (
        .clk(clk), .rst(rst), .ce(ce), .lsr(lsr),
        .lut_out(lut_out), .dir_in(dir_in), .spare_d(spare_d),
        .honour_ce(honour_ce), .honour_lsr(honour_lsr),
        .lsr_level(lsr_level), .use_direct(use_direct),
        .spare_honour_ce(spare_honour_ce), .spare_honour_lsr(spare_honour_lsr),
        .spare_lsr_level(spare_lsr_level),
        .q(q), .spare_q(spare_q)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_plain();
        ce = 1'b1; lsr = 1'b0;
        honour_ce = 2'b00; honour_lsr = 2'b00; lsr_level = 2'b00; use_direct = 2'b00;
        spare_honour_ce = 1'b0; spare_honour_lsr = 1'b0; spare_lsr_level = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_plain();
        lut_out = 8'hFF; dir_in = 8'hFF; spare_d = 1'b1;
        step();
        check("R1 reset clears", {spare_q, q}, 9'h000);
        rst = 1'b0;
    endtask

    task automatic t_source();
        cfg_plain();
        lut_out = 8'hA5; dir_in = 8'h3C; spare_d = 1'b0;
        use_direct = 2'b10;
        step();
        check("R2 nib1 direct nib0 lut", {spare_q, q}, 9'h035);
        use_direct = 2'b01;
        step();
        check("R2 nib1 lut nib0 direct", {spare_q, q}, 9'h0AC);
    endtask

    task automatic t_ce();
        cfg_plain();
        lut_out = 8'h12; step();
        honour_ce = 2'b11; ce = 1'b0; lut_out = 8'hEE;
        step();
        check("R3 both nibbles hold", {spare_q, q}, 9'h012);
        honour_ce = 2'b01;
        step();
        check("R4 nib1 ignores ce", {spare_q, q}, 9'h0E2);
        ce = 1'b1;
        step();
        check("R3 enable releases", {spare_q, q}, 9'h0EE);
    endtask

    task automatic t_lsr();
        cfg_plain();
        lut_out = 8'h5A; step();
        honour_lsr = 2'b11; lsr_level = 2'b01; lsr = 1'b1;
        step();
        check("R5 force per-nibble level", {spare_q, q}, 9'h00F);
        lsr_level = 2'b10; honour_ce = 2'b11; ce = 1'b0;
        step();
        check("R6 lsr beats disabled ce", {spare_q, q}, 9'h0F0);
        honour_ce = 2'b00; ce = 1'b1;
        honour_lsr = 2'b01; lsr_level = 2'b11; lut_out = 8'h69;
        step();
        check("R7 nib1 ignores lsr", {spare_q, q}, 9'h06F);
        honour_ce = 2'b10; ce = 1'b0; lut_out = 8'h33;
        step();
        check("R7 nib1 holds by ce despite lsr", {spare_q, q}, 9'h06F);
    endtask

    task automatic t_spare();
        cfg_plain();
        lut_out = 8'h00; spare_d = 1'b1;
        step();
        check("R8 spare loads", {spare_q, q}, 9'h100);
        spare_honour_ce = 1'b1; ce = 1'b0; spare_d = 1'b0; lut_out = 8'h77;
        step();
        check("R8 spare holds, nibbles load", {spare_q, q}, 9'h177);
        spare_honour_lsr = 1'b1; spare_lsr_level = 1'b0; lsr = 1'b1; honour_lsr = 2'b00;
        spare_d = 1'b1; lut_out = 8'h11;
        step();
        check("R8 spare forced alone", {spare_q, q}, 9'h011);
        spare_lsr_level = 1'b1; spare_honour_lsr = 1'b1;
        step();
        check("R8 spare forced to one", {spare_q, q}, 9'h111);
    endtask

    task automatic t_latency();
        cfg_plain();
        lut_out = 8'h00; spare_d = 1'b0; step();
        lut_out = 8'hC3;
        #2;
        check("R9 no change before edge", {spare_q, q}, 9'h000);
        step();
        check("R9 change after edge", {spare_q, q}, 9'h0C3);
    endtask

    initial begin
        rst = 1'b1; cfg_plain();
        lut_out = '0; dir_in = '0; spare_d = 1'b0;
        @(negedge clk);
        t_reset();
        t_source();
        t_ce();
        t_lsr();
        t_spare();
        t_latency();
        rst = 1'b1; lut_out = 8'hFF; spare_d = 1'b1;
        step();
        check("R1 reset mid-run", {spare_q, q}, 9'h000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule